// File: doc/BRIEF.md
# Zero-Address Stack Execution Unit

This block executes a stream of zero-address instructions on an eight-entry operand stack. Values reach the stack only by push: either as an immediate carried in the instruction or by reading a word of a small synchronous data memory. A pop removes the top entry and writes it to an addressed memory word. The arithmetic instructions (add, subtract, multiply) name no operands. Each one takes the top two entries, removes the top one and overwrites the entry below it with the result, so the stack shrinks by one.

Instructions arrive on a valid/ready handshake. An immediate push, a pop and every arithmetic instruction complete in the cycle they are accepted. A memory push stalls the handshake for one extra cycle while the read data returns. The current stack depth is always visible. Two sticky flags record overflow (a push onto a full stack) and underflow (a pop from an empty stack, or arithmetic with fewer than two entries). In both error cases the stack is left untouched and memory is not accessed.

Top module: `stk_exec_unit`

## Requirements
- R1: After reset the depth is 0, both error flags are 0 and `ins_ready` is 1.
- R2: Opcode 1 pushes the 24-bit `ins_arg` as an immediate; it is accepted in one cycle and the depth rises by one.
- R3: Opcode 0 pushes a memory word: in the accepting cycle `mem_req`=1, `mem_we`=0 and `mem_addr`=`ins_arg[AW-1:0]`. `ins_ready` is 0 for the following cycle, and the word read back becomes the new top.
- R4: Opcode 2 pops: in the accepting cycle `mem_req`=1, `mem_we`=1, `mem_addr`=`ins_arg[AW-1:0]` and `mem_wdata` is the top entry. The depth then drops by one.
- R5: Opcode 3 replaces the top two entries by their sum modulo 2^24, lowering the depth by one and leaving deeper entries unchanged.
- R6: Opcode 4 replaces the top two entries by (second minus top) modulo 2^24.
- R7: Opcode 5 replaces the top two entries by the low 24 bits of their product.
- R8: A push of either kind when the depth is 8 sets the sticky `ovf_flag`, leaves the stack unchanged and makes no memory request.
- R9: A pop at depth 0, or arithmetic at depth below 2, sets the sticky `udf_flag`, leaves the stack unchanged and makes no memory write.
- R10: Opcodes 6 and 7 are accepted and have no effect on the stack, the flags or memory.
- R11: The stack is last-in first-out across all 8 entries, including the entries held below the top two.
- R12: The program push B, push C, add, push D, mul, push E, sub, pop F stores (B+C)*D-E, wrapped to 24 bits, at F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Instruction present |
| ins_ready | output | 1 | Unit can accept an instruction |
| ins_op | input | 3 | Opcode (0 push-mem, 1 push-imm, 2 pop, 3 add, 4 sub, 5 mul) |
| ins_arg | input | DW (24) | Immediate value, or memory address in its low AW bits |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW (10) | Word address |
| mem_wdata | output | DW (24) | Write data (top of stack) |
| mem_rdata | input | DW (24) | Read data, valid the cycle after a read request |
| depth | output | 4 | Number of stack entries |
| ovf_flag | output | 1 | Sticky overflow |
| udf_flag | output | 1 | Sticky underflow |

## Verification
The hardest state to reach is a completely full stack, where six of the eight values sit in the spill array and only the top two are in registers. From there, a rejected push of each kind must leave every entry intact. The bench fills the stack with eight distinct immediates and attempts both an immediate and a memory push. It then drains all eight entries to memory and compares them in reverse order, which exposes any spill-array index that is off by one. Wrap-around in all three arithmetic operations is driven with operands chosen near 2^24.

// File: rtl/stk_pkg.sv
package stk_pkg;
  // Instruction opcodes; values 6 and 7 are unused and ignored
  typedef enum logic [2:0] {
    OP_LDM = 3'd0,
    OP_LDI = 3'd1,
    OP_STM = 3'd2,
    OP_ADD = 3'd3,
    OP_SUB = 3'd4,
    OP_MUL = 3'd5
  } op_e;

  // Command from control to storage
  typedef enum logic [1:0] {
    SC_NONE = 2'd0,
    SC_PUSH = 2'd1,
    SC_POP  = 2'd2,
    SC_FOLD = 2'd3
  } stk_cmd_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } st_e;
endpackage

// File: rtl/stk_alu.sv
module stk_alu #(
  parameter int DW = 24
) (
  input  logic [2:0]    op,
  input  logic [DW-1:0] sos,
  input  logic [DW-1:0] tos,
  output logic [DW-1:0] res
);
  import stk_pkg::*;

  function automatic logic [DW-1:0] f_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a + b;
  endfunction

  // second entry minus top entry
  function automatic logic [DW-1:0] f_sub(input logic [DW-1:0] s, input logic [DW-1:0] t);
    return s - t;
  endfunction

  // product taken at DW width keeps only the low bits
  function automatic logic [DW-1:0] f_mul(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a * b;
  endfunction

  always_comb begin
    case (op)
      OP_ADD:  res = f_add(sos, tos);
      OP_SUB:  res = f_sub(sos, tos);
      OP_MUL:  res = f_mul(sos, tos);
      default: res = tos;
    endcase
  end
endmodule

// File: rtl/stk_store.sv
module stk_store #(
  parameter int DW    = 24,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  stk_pkg::stk_cmd_e      cmd,
  input  logic [DW-1:0]          wval,
  output logic [DW-1:0]          tos,
  output logic [DW-1:0]          sos,
  output logic [CW-1:0]          count
);
  import stk_pkg::*;

  localparam int SPILL = DEPTH - 2;
  localparam int IW    = (SPILL > 1) ? $clog2(SPILL) : 1;

  logic [DW-1:0] spill [SPILL];
  logic [IW-1:0] wr_idx, rd_idx;
  logic          has_spill_wr, has_spill_rd;
  logic [DW-1:0] refill;

  assign wr_idx       = IW'(count - CW'(2));
  assign rd_idx       = IW'(count - CW'(3));
  assign has_spill_wr = (count >= CW'(2));
  assign has_spill_rd = (count >= CW'(3));
  assign refill       = has_spill_rd ? spill[rd_idx] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tos   <= '0;
      sos   <= '0;
      count <= '0;
    end else begin
      case (cmd)
        SC_PUSH: begin
          tos   <= wval;
          sos   <= tos;
          count <= count + CW'(1);
        end
        SC_POP: begin
          tos   <= sos;
          sos   <= refill;
          count <= count - CW'(1);
        end
        SC_FOLD: begin
          tos   <= wval;
          sos   <= refill;
          count <= count - CW'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (cmd == SC_PUSH && has_spill_wr) spill[wr_idx] <= sos;
  end
endmodule

// File: rtl/stk_exec_unit.sv
module stk_exec_unit #(
  parameter int DW    = 24,
  parameter int AW    = 10,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  output logic          ins_ready,
  input  logic [2:0]    ins_op,
  input  logic [DW-1:0] ins_arg,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [CW-1:0] depth,
  output logic          ovf_flag,
  output logic          udf_flag
);
  import stk_pkg::*;

  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  st_e           st_q;
  stk_cmd_e      cmd;
  logic [DW-1:0] tos, sos, alu_res, wval;
  logic [CW-1:0] count;

  // named events used by the control and the checker
  logic acc_fire, is_push, is_pop, is_bin;
  logic full, empty, few;
  logic ovf_event, udf_event, rd_start, wr_start, bin_ok, imm_ok;

  assign ins_ready = (st_q == ST_IDLE);
  assign acc_fire  = ins_valid && ins_ready;
  assign is_push   = (ins_op == OP_LDM) || (ins_op == OP_LDI);
  assign is_pop    = (ins_op == OP_STM);
  assign is_bin    = (ins_op == OP_ADD) || (ins_op == OP_SUB) || (ins_op == OP_MUL);
  assign full      = (count == FULL_C);
  assign empty     = (count == '0);
  assign few       = (count < CW'(2));

  assign ovf_event = acc_fire && is_push && full;
  assign udf_event = acc_fire && ((is_pop && empty) || (is_bin && few));
  assign rd_start  = acc_fire && (ins_op == OP_LDM) && !full;
  assign imm_ok    = acc_fire && (ins_op == OP_LDI) && !full;
  assign wr_start  = acc_fire && is_pop && !empty;
  assign bin_ok    = acc_fire && is_bin && !few;

  assign mem_req   = rd_start || wr_start;
  assign mem_we    = wr_start;
  assign mem_addr  = ins_arg[AW-1:0];
  assign mem_wdata = tos;
  assign depth     = count;

  stk_alu #(.DW(DW)) u_alu (
    .op (ins_op),
    .sos(sos),
    .tos(tos),
    .res(alu_res)
  );

  always_comb begin
    cmd  = SC_NONE;
    wval = alu_res;
    if (st_q == ST_FETCH) begin
      cmd  = SC_PUSH;
      wval = mem_rdata;
    end else if (imm_ok) begin
      cmd  = SC_PUSH;
      wval = ins_arg;
    end else if (wr_start) begin
      cmd  = SC_POP;
    end else if (bin_ok) begin
      cmd  = SC_FOLD;
    end
  end

  stk_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk  (clk),
    .rst_n(rst_n),
    .cmd  (cmd),
    .wval (wval),
    .tos  (tos),
    .sos  (sos),
    .count(count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      ovf_flag <= 1'b0;
      udf_flag <= 1'b0;
    end else begin
      st_q <= rd_start ? ST_FETCH : ST_IDLE;
      if (ovf_event) ovf_flag <= 1'b1;
      if (udf_event) udf_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/stk_exec_chk.sv
module stk_exec_chk #(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ins_ready,
  input logic          acc_fire,
  input logic          ovf_event,
  input logic          udf_event,
  input logic          mem_req,
  input logic          mem_we,
  input logic [CW-1:0] depth,
  input logic          ovf_flag,
  input logic          udf_flag
);
  p_depth_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CW'(DEPTH));

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  p_udf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    udf_flag |=> udf_flag);

  p_ovf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_event |=> ovf_flag);

  p_ovf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_event |=> depth == $past(depth));

  p_udf_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    udf_event |=> depth == $past(depth));

  p_no_mem_on_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_event || udf_event) |-> !mem_req);

  p_wr_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> depth != '0);

  p_fetch_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> !ins_ready);

  p_req_needs_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> acc_fire);
endmodule

bind stk_exec_unit stk_exec_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ins_ready(ins_ready),
  .acc_fire (acc_fire),
  .ovf_event(ovf_event),
  .udf_event(udf_event),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .depth    (depth),
  .ovf_flag (ovf_flag),
  .udf_flag (udf_flag)
);

// File: tb/stk_exec_unit_tb.sv
module stk_exec_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 24;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ins_valid = 1'b0;
  logic          ins_ready;
  logic [2:0]    ins_op = '0;
  logic [DW-1:0] ins_arg = '0;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [3:0]    depth;
  logic          ovf_flag, udf_flag;

  logic [DW-1:0] mem [1024];

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic          cap_req, cap_we;
  logic [AW-1:0] cap_addr;
  logic [DW-1:0] cap_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  stk_exec_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_op(ins_op), .ins_arg(ins_arg),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .depth(depth), .ovf_flag(ovf_flag), .udf_flag(udf_flag)
  );

  // synchronous memory model
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata     <= mem[mem_addr];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ins_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] op, input logic [DW-1:0] arg);
    while (!ins_ready) @(negedge clk);
    ins_op = op;
    ins_arg = arg;
    ins_valid = 1'b1;
    #1;
    cap_req = mem_req; cap_we = mem_we; cap_addr = mem_addr; cap_wdata = mem_wdata;
    @(negedge clk);
    ins_valid = 1'b0;
  endtask

  task automatic settle();
    while (!ins_ready) @(negedge clk);
  endtask

  task automatic pop_chk(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    issue(3'd2, DW'(a));
    chk({tag, " pop req"}, {30'd0, cap_req, cap_we}, 32'h3);
    chk({tag, " pop data"}, 32'(cap_wdata), 32'(exp));
    chk({tag, " pop mem"}, 32'(mem[a]), 32'(exp));
  endtask

  task automatic t_reset();
    chk("R1 depth", 32'(depth), 0);
    chk("R1 flags", {30'd0, ovf_flag, udf_flag}, 0);
    chk("R1 ready", 32'(ins_ready), 1);
  endtask

  task automatic t_push_imm();
    issue(3'd1, 24'h1ABCDE);
    chk("R2 depth", 32'(depth), 1);
    chk("R2 no mem", 32'(cap_req), 0);
    pop_chk(10'd5, 24'h1ABCDE, "R4 imm");
    chk("R4 depth", 32'(depth), 0);
  endtask

  task automatic t_push_mem();
    mem[17] = 24'h345678;
    issue(3'd0, 24'd17);
    chk("R3 req", {30'd0, cap_req, cap_we}, 32'h2);
    chk("R3 addr", 32'(cap_addr), 17);
    chk("R3 stall", 32'(ins_ready), 0);
    settle();
    chk("R3 depth", 32'(depth), 1);
    pop_chk(10'd18, 24'h345678, "R3 value");
  endtask

  task automatic t_arith();
    logic [47:0] prod;
    issue(3'd1, 24'hFFFFFF); issue(3'd1, 24'h000002); issue(3'd3, 0);
    chk("R5 depth", 32'(depth), 1);
    pop_chk(10'd20, 24'h000001, "R5 wrap");
    issue(3'd1, 24'd100); issue(3'd1, 24'd3); issue(3'd1, 24'd5); issue(3'd4, 0);
    chk("R6 depth", 32'(depth), 2);
    pop_chk(10'd21, 24'hFFFFFE, "R6 sub order");
    pop_chk(10'd22, 24'd100, "R5 deeper kept");
    prod = 48'h123456 * 48'h00ABCD;
    issue(3'd1, 24'h123456); issue(3'd1, 24'h00ABCD); issue(3'd5, 0);
    pop_chk(10'd23, prod[23:0], "R7 mul low");
    issue(3'd1, 24'h001000); issue(3'd1, 24'h001000); issue(3'd5, 0);
    pop_chk(10'd24, 24'h0, "R7 mul wrap");
  endtask

  task automatic t_full();
    for (int i = 1; i <= 8; i++) issue(3'd1, DW'(i * 16 + 1));
    chk("R11 depth full", 32'(depth), 8);
    issue(3'd1, 24'd99);
    chk("R8 ovf imm", 32'(ovf_flag), 1);
    chk("R8 depth kept", 32'(depth), 8);
    issue(3'd0, 24'd17);
    chk("R8 no read", 32'(cap_req), 0);
    settle();
    chk("R8 depth kept mem", 32'(depth), 8);
    for (int i = 8; i >= 1; i--) pop_chk(AW'(100 + i), DW'(i * 16 + 1), "R11 lifo");
    chk("R8 sticky", 32'(ovf_flag), 1);
    do_reset();
  endtask

  task automatic t_under();
    issue(3'd2, 24'd30);
    chk("R9 no write", 32'(cap_req), 0);
    chk("R9 udf pop", 32'(udf_flag), 1);
    chk("R9 depth", 32'(depth), 0);
    issue(3'd1, 24'd5);
    issue(3'd3, 0);
    chk("R9 depth one", 32'(depth), 1);
    pop_chk(10'd31, 24'd5, "R9 kept");
    chk("R9 sticky", 32'(udf_flag), 1);
    do_reset();
  endtask

  task automatic t_illegal();
    issue(3'd1, 24'd9);
    issue(3'd6, 24'd40);
    chk("R10 op6 mem", 32'(cap_req), 0);
    issue(3'd7, 24'd40);
    chk("R10 op7 mem", 32'(cap_req), 0);
    chk("R10 depth", 32'(depth), 1);
    chk("R10 flags", {30'd0, ovf_flag, udf_flag}, 0);
    pop_chk(10'd41, 24'd9, "R10 kept");
  endtask

  task automatic t_program();
    logic [47:0] e;
    mem[50] = 24'h700000; mem[51] = 24'h200000; mem[52] = 24'd3; mem[53] = 24'd1;
    e = ((48'h700000 + 48'h200000) * 48'd3) - 48'd1;
    issue(3'd0, 24'd50); issue(3'd0, 24'd51); issue(3'd3, 0);
    issue(3'd0, 24'd52); issue(3'd5, 0);
    issue(3'd0, 24'd53); issue(3'd4, 0);
    issue(3'd2, 24'd60);
    settle();
    chk("R12 result", 32'(mem[60]), 32'(e[23:0]));
    chk("R12 depth", 32'(depth), 0);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_push_imm();
    t_push_mem();
    t_arith();
    t_full();
    t_under();
    t_illegal();
    t_program();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule